// File: doc/BRIEF.md
# AXI Burst Efficiency Monitor

A passive observer that sits beside one AXI address channel and its matching data channel and grades every transaction on two independent axes. The first is length amortization: the fixed non-data cost of the address phase spread over the data beats that follow it. The second is lane utilization: the share of the bus's byte lanes that each beat fills for the transfer size in use. Reporting the two factors separately shows whether a poor result comes from a short burst or from a narrow one. Their product gives the overall figure.

For each transaction the monitor counts the cycles the address request is held valid and the data handshakes up to the beat flagged last. A small sequential divider then turns these counts into an unsigned Q0.16 fraction. When the fractions are ready, all per-transaction results are latched together and flagged with a one-cycle strobe. Saturating running totals of beats, overhead cycles and lane bytes let software-free averaging be derived outside the block. A synchronous clear input resets the totals.

Top module: `burst_eff_mon`

## Requirements
- R1: `txn_ovh` reports the number of cycles `addr_valid` was high for the transaction, counting from its first valid cycle up to and including the handshake cycle. The count saturates at 2^OVH_W-1, which is 255 by default.
- R2: `txn_beats` reports the number of data handshakes (`data_valid` and `data_ready` both high), counting up to and including the one with `data_last` high. Cycles in which `data_valid` is low add nothing.
- R3: `len_factor` equals floor(N·2^16 / (N + ovh)), where N is the beat count and ovh is the overhead count. One beat with one overhead cycle gives 0x8000, and 16 beats with one overhead cycle gives 61680.
- R4: `width_factor` equals 2^size·2^16 / BUS_BYTES for the captured `addr_size`. A size of 0 on the default 8-byte bus gives 0x2000. A full-width size, or any larger one, reports 0xFFFF.
- R5: `total_factor` equals floor(`len_factor` × `width_factor` / 2^16).
- R6: `metric_valid` is a one-cycle pulse that rises exactly FRAC_W+1 clock edges after the edge that samples the last beat. This is 17 edges by default. All per-transaction outputs change only at that pulse and hold until the next one.
- R7: At the edge that samples the last beat, the totals add the beat count, the overhead count and the lane bytes (N·2^size). Each total saturates at 2^CNT_W-1 instead of wrapping.
- R8: A `clr` high at a clock edge zeroes all three totals at that edge. It takes priority over a last-beat update in the same cycle.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the running totals |
| addr_valid | input | 1 | Observed address-channel valid |
| addr_ready | input | 1 | Observed address-channel ready |
| addr_size | input | 3 | Observed transfer size, log2 of bytes per beat |
| data_valid | input | 1 | Observed data-channel valid |
| data_ready | input | 1 | Observed data-channel ready |
| data_last | input | 1 | Observed last-beat flag |
| metric_valid | output | 1 | One-cycle strobe: new per-transaction results |
| txn_beats | output | BEAT_W (9) | Data beats of the last transaction |
| txn_ovh | output | OVH_W (8) | Overhead cycles of the last transaction |
| len_factor | output | FRAC_W (16) | Length factor, Q0.16 |
| width_factor | output | FRAC_W (16) | Width factor, Q0.16 |
| total_factor | output | FRAC_W (16) | Product of both factors, Q0.16 |
| tot_beats | output | CNT_W (32) | Saturating total of beats |
| tot_ovh | output | CNT_W (32) | Saturating total of overhead cycles |
| tot_bytes | output | CNT_W (32) | Saturating total of lane bytes |

## Verification
The assertions assume strict single-ID, in-order traffic. The address handshake for a transaction comes before its first data beat. No new address is accepted, and no last beat arrives, while the divider is still working on the previous transaction. The assertions also assume that every transaction holds the address valid for at least one cycle, so the divisor always exceeds the dividend. The bench drives each transaction to completion and waits for the result strobe before it starts the next address phase. This keeps the divider idle whenever a new start arrives. The bench runs with a 12-bit total width so that saturation is reached within a short run.

// File: rtl/burst_eff_pkg.sv
package burst_eff_pkg;

  // Q0.fw share of the bus filled by a beat of 2^sz bytes on a 2^lg-byte bus.
  // A full-width or wider size is clamped to the largest representable value.
  function automatic int unsigned lane_share(input int unsigned sz,
                                             input int unsigned lg,
                                             input int unsigned fw);
    if (sz >= lg) return (32'd1 << fw) - 32'd1;
    return 32'd1 << (fw - lg + sz);
  endfunction

endpackage

// File: rtl/beff_divider.sv
module beff_divider #(
  parameter int NW = 10,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quo
);
  localparam int CW = $clog2(QW);

  logic          busy_q, busy_d, done_q, done_d;
  logic [NW-1:0] rem_q, rem_d, den_q, den_d;
  logic [QW-1:0] quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW:0]   rem_sh;
  logic          take;

  always_comb begin
    rem_sh = {rem_q, 1'b0};
    take   = rem_sh >= {1'b0, den_q};
    busy_d = busy_q;
    done_d = 1'b0;
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    if (start) begin
      rem_d  = num;
      den_d  = den;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = take ? NW'(rem_sh - {1'b0, den_q}) : rem_sh[NW-1:0];
      quo_d = {quo_q[QW-2:0], take};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(QW-1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;

  // R6: completion strobe lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: a new transaction never lands on a running division (input rule)
  a_r6_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R3: the partial remainder stays below the divisor, so the quotient is a fraction
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> rem_q < den_q);
endmodule

// File: rtl/beff_sat_acc.sv
module beff_sat_acc #(
  parameter int CW = 32,
  parameter int IW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] inc,
  output logic [CW-1:0] acc
);
  localparam int SW = ((CW > IW) ? CW : IW) + 1;

  logic [CW-1:0] acc_q, acc_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = SW'(acc_q) + SW'(inc);
    acc_d = acc_q;
    if (clr)
      acc_d = '0;
    else if (en)
      acc_d = (sum > SW'({CW{1'b1}})) ? {CW{1'b1}} : CW'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R7: a total never wraps downward unless cleared
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc_q >= $past(acc_q));
  // R8: clear zeroes the total at that edge
  a_r8_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc_q == '0);
endmodule

// File: rtl/burst_eff_mon.sv
module burst_eff_mon
  import burst_eff_pkg::*;
#(
  parameter int BUS_BYTES = 8,
  parameter int BEAT_W    = 9,
  parameter int OVH_W     = 8,
  parameter int FRAC_W    = 16,
  parameter int CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              addr_valid,
  input  logic              addr_ready,
  input  logic [2:0]        addr_size,
  input  logic              data_valid,
  input  logic              data_ready,
  input  logic              data_last,
  output logic              metric_valid,
  output logic [BEAT_W-1:0] txn_beats,
  output logic [OVH_W-1:0]  txn_ovh,
  output logic [FRAC_W-1:0] len_factor,
  output logic [FRAC_W-1:0] width_factor,
  output logic [FRAC_W-1:0] total_factor,
  output logic [CNT_W-1:0]  tot_beats,
  output logic [CNT_W-1:0]  tot_ovh,
  output logic [CNT_W-1:0]  tot_bytes
);
  localparam int LANE_LG = $clog2(BUS_BYTES);
  localparam int DEN_W   = ((BEAT_W > OVH_W) ? BEAT_W : OVH_W) + 1;
  localparam int INC_W   = BEAT_W + 8;
  localparam int NACC    = 3;

  logic a_hs, d_hs, end_hs;
  assign a_hs   = addr_valid & addr_ready;
  assign d_hs   = data_valid & data_ready;
  assign end_hs = d_hs & data_last;

  // address-phase overhead and size capture
  logic [OVH_W-1:0]  ovh_run_q, ovh_run_d, ovh_cap_q, ovh_cap_d, ovh_inc;
  logic [2:0]        sz_cap_q, sz_cap_d;
  // data beat counting
  logic [BEAT_W-1:0] beat_run_q, beat_run_d, n_end;
  // values handed to the divider
  logic [BEAT_W-1:0] calc_beats_q, calc_beats_d;
  logic [OVH_W-1:0]  calc_ovh_q, calc_ovh_d;
  logic [2:0]        calc_sz_q, calc_sz_d;
  // published results
  logic              mv_q;
  logic [BEAT_W-1:0] out_beats_q, out_beats_d;
  logic [OVH_W-1:0]  out_ovh_q, out_ovh_d;
  logic [FRAC_W-1:0] len_q, len_d, wid_q, wid_d;

  logic              div_busy, div_done;
  logic [FRAC_W-1:0] div_quo;
  logic [DEN_W-1:0]  div_num, div_den;

  always_comb begin
    ovh_inc = (ovh_run_q == {OVH_W{1'b1}}) ? ovh_run_q : ovh_run_q + 1'b1;
    n_end   = (beat_run_q == {BEAT_W{1'b1}}) ? beat_run_q : beat_run_q + 1'b1;

    ovh_run_d = ovh_run_q;
    ovh_cap_d = ovh_cap_q;
    sz_cap_d  = sz_cap_q;
    if (a_hs) begin
      ovh_cap_d = ovh_inc;
      sz_cap_d  = addr_size;
      ovh_run_d = '0;
    end else if (addr_valid) begin
      ovh_run_d = ovh_inc;
    end

    beat_run_d = beat_run_q;
    if (end_hs)    beat_run_d = '0;
    else if (d_hs) beat_run_d = n_end;

    calc_beats_d = calc_beats_q;
    calc_ovh_d   = calc_ovh_q;
    calc_sz_d    = calc_sz_q;
    if (end_hs) begin
      calc_beats_d = n_end;
      calc_ovh_d   = ovh_cap_q;
      calc_sz_d    = sz_cap_q;
    end

    out_beats_d = out_beats_q;
    out_ovh_d   = out_ovh_q;
    len_d       = len_q;
    wid_d       = wid_q;
    if (div_done) begin
      out_beats_d = calc_beats_q;
      out_ovh_d   = calc_ovh_q;
      len_d       = div_quo;
      wid_d       = FRAC_W'(lane_share(32'(calc_sz_q), LANE_LG, FRAC_W));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovh_run_q    <= '0;
      ovh_cap_q    <= '0;
      sz_cap_q     <= '0;
      beat_run_q   <= '0;
      calc_beats_q <= '0;
      calc_ovh_q   <= '0;
      calc_sz_q    <= '0;
      mv_q         <= 1'b0;
      out_beats_q  <= '0;
      out_ovh_q    <= '0;
      len_q        <= '0;
      wid_q        <= '0;
    end else begin
      ovh_run_q    <= ovh_run_d;
      ovh_cap_q    <= ovh_cap_d;
      sz_cap_q     <= sz_cap_d;
      beat_run_q   <= beat_run_d;
      calc_beats_q <= calc_beats_d;
      calc_ovh_q   <= calc_ovh_d;
      calc_sz_q    <= calc_sz_d;
      mv_q         <= div_done;
      out_beats_q  <= out_beats_d;
      out_ovh_q    <= out_ovh_d;
      len_q        <= len_d;
      wid_q        <= wid_d;
    end
  end

  assign div_num = DEN_W'(n_end);
  assign div_den = DEN_W'(n_end) + DEN_W'(ovh_cap_q);

  beff_divider #(.NW(DEN_W), .QW(FRAC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (end_hs),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  logic [NACC-1:0][INC_W-1:0] acc_inc;
  logic [NACC-1:0][CNT_W-1:0] acc_val;
  assign acc_inc[0] = INC_W'(n_end);
  assign acc_inc[1] = INC_W'(ovh_cap_q);
  assign acc_inc[2] = INC_W'(n_end) << sz_cap_q;

  for (genvar g = 0; g < NACC; g++) begin : g_tot
    beff_sat_acc #(.CW(CNT_W), .IW(INC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (end_hs),
      .inc   (acc_inc[g]),
      .acc   (acc_val[g])
    );
  end

  assign metric_valid = mv_q;
  assign txn_beats    = out_beats_q;
  assign txn_ovh      = out_ovh_q;
  assign len_factor   = len_q;
  assign width_factor = wid_q;
  assign total_factor = FRAC_W'((2*FRAC_W)'(len_q) * (2*FRAC_W)'(wid_q) >> FRAC_W);
  assign tot_beats    = acc_val[0];
  assign tot_ovh      = acc_val[1];
  assign tot_bytes    = acc_val[2];

  // R2: a last beat never lands while the previous division runs (input rule)
  a_r2_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    end_hs |-> !div_busy);
  // R1: every reported transaction carries at least one overhead cycle
  a_r1_ovh_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> txn_ovh != '0);
  // R3: a reported length factor is never zero
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> len_factor != '0);
  // R4: a reported width factor is never zero
  a_r4_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    metric_valid |-> width_factor != '0);
  // R6: published results hold between strobes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !div_done |=> $stable(len_factor) && $stable(txn_beats));
endmodule

// File: tb/sim_burst_eff_mon.sv
`timescale 1ns/1ps
module sim_burst_eff_mon;
  localparam int CW  = 12;
  localparam int FW  = 16;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk, rst_n, clr;
  logic addr_valid, addr_ready, data_valid, data_ready, data_last;
  logic [2:0] addr_size;
  logic metric_valid;
  logic [8:0] txn_beats;
  logic [7:0] txn_ovh;
  logic [15:0] len_factor, width_factor, total_factor;
  logic [CW-1:0] tot_beats, tot_ovh, tot_bytes;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;
  longint m_beats = 0, m_ovh = 0, m_bytes = 0;

  burst_eff_mon #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_size(addr_size),
    .data_valid(data_valid), .data_ready(data_ready), .data_last(data_last),
    .metric_valid(metric_valid), .txn_beats(txn_beats), .txn_ovh(txn_ovh),
    .len_factor(len_factor), .width_factor(width_factor), .total_factor(total_factor),
    .tot_beats(tot_beats), .tot_ovh(tot_ovh), .tot_bytes(tot_bytes)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat_add(input longint a, input longint b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  // one transaction: aw stall cycles before address ready, nb beats, optional data gaps
  task automatic run_txn(input int sz, input int nb, input int aw, input bit gap,
                         input bit clr_end, input string tag);
    int lat;
    longint ovh, el, ew;
    for (int c = 0; c <= aw; c++) begin
      @(negedge clk);
      addr_valid = 1'b1; addr_ready = (c == aw); addr_size = 3'(sz);
      @(posedge clk);
    end
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      addr_valid = 1'b0; addr_ready = 1'b0;
      if (gap) begin
        data_valid = 1'b0; data_ready = 1'b1;
        @(negedge clk);
      end
      data_valid = 1'b1; data_ready = 1'b1; data_last = (b == nb - 1);
      clr = clr_end && (b == nb - 1);
      @(posedge clk);
    end
    @(negedge clk);
    data_valid = 1'b0; data_last = 1'b0; clr = 1'b0;
    lat = 0;
    while (lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
      if (metric_valid) break;
    end
    ovh = (aw + 1 > 255) ? 255 : aw + 1;
    el  = (longint'(nb) * 65536) / (nb + ovh);
    ew  = (sz >= 3) ? 65535 : (64'd1 << (13 + sz));
    if (clr_end) begin
      m_beats = 0; m_ovh = 0; m_bytes = 0;
    end else begin
      m_beats = sat_add(m_beats, nb);
      m_ovh   = sat_add(m_ovh, ovh);
      m_bytes = sat_add(m_bytes, longint'(nb) << sz);
    end
    chk({tag, " R6 latency"}, lat, FW + 1);
    chk({tag, " R1 ovh"}, txn_ovh, ovh);
    chk({tag, " R2 beats"}, txn_beats, nb);
    chk({tag, " R3 len"}, len_factor, el);
    chk({tag, " R4 width"}, width_factor, ew);
    chk({tag, " R5 total"}, total_factor, (el * ew) >> 16);
    chk({tag, " R7 tot_beats"}, tot_beats, m_beats);
    chk({tag, " R7 tot_ovh"}, tot_ovh, m_ovh);
    chk({tag, " R7 tot_bytes"}, tot_bytes, m_bytes);
    @(negedge clk);
    chk({tag, " R6 pulse"}, metric_valid, 0);
    chk({tag, " R6 hold"}, len_factor, el);
  endtask

  task automatic t_reset();
    chk("R9 reset mv", metric_valid, 0);
    chk("R9 reset len", len_factor, 0);
    chk("R9 reset width", width_factor, 0);
    chk("R9 reset beats", txn_beats, 0);
    chk("R9 reset tot", tot_bytes, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_beats = 0; m_ovh = 0; m_bytes = 0;
    chk("R8 clr beats", tot_beats, 0);
    chk("R8 clr ovh", tot_ovh, 0);
    chk("R8 clr bytes", tot_bytes, 0);
  endtask

  task automatic t_saturate();
    run_txn(3, 256, 0, 0, 0, "sat1");
    run_txn(3, 256, 0, 0, 0, "sat2");
    chk("R7 saturated bytes", tot_bytes, CMAX);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0;
    addr_valid = 1'b0; addr_ready = 1'b0; addr_size = 3'd0;
    data_valid = 1'b0; data_ready = 1'b0; data_last = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_txn(3, 1, 0, 0, 0, "single");
    run_txn(3, 16, 0, 0, 0, "sixteen");
    run_txn(0, 4, 2, 1, 0, "narrow");
    run_txn(2, 8, 1, 0, 0, "half");
    run_txn(3, 256, 0, 0, 0, "long");
    run_txn(3, 2, 300, 0, 0, "ovh_sat");
    t_clear();
    t_saturate();
    run_txn(1, 3, 0, 0, 1, "clr_end");
    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule